// File: doc/BRIEF.md
# VGA Planar Write Datapath

This block turns one byte written by the CPU into the data and enables for a four-plane VGA frame buffer. It produces a 32-bit write word, one byte per plane, and a 4-bit plane enable. A packed set of control fields steers the byte through four stages. A right rotator comes first. Set/reset substitution may replace the byte for each plane. A bit mask then picks, bit by bit, between the processed data and the byte held for that plane in the 32-bit display latch.

Three write modes are supported: normal (mode 0), mode 2 and mode 3. Chain-4 and chain-2 (odd/even) addressing narrow the plane enable using the low address bits. Both outputs are registered, so a write presented on one rising edge appears at the outputs after that edge and stays there for one cycle.

Top module: `vga_plane_writer`

## Requirements
- R1: All outputs are zero after reset. Outputs follow the inputs sampled at the previous rising edge. When `wr_valid` is low, `plane_en` is 0 on the next cycle.
- R2: In mode 0, a plane whose set/reset enable bit is 0 takes the CPU byte rotated right by `rot_cnt` places: result bit i equals data bit (i+rot_cnt) mod 8.
- R3: In mode 0, a plane p with `sr_en[p]=1` takes the byte formed by repeating `sr_val[p]` eight times, in place of the rotated data.
- R4: Byte p of `wr_data` (bits 8p+7..8p) has each bit taken from the processed data where the effective mask bit is 1, and from latch byte p (`latch` bits 8p+7..8p) where it is 0. In modes 0 and 2 the effective mask is `bit_mask`.
- R5: When `mode2` is 1 and `mode3` is 0, plane p's processed byte is `cpu_data[p]` repeated eight times. The unrotated byte is used, and `sr_en` has no effect.
- R6: When `mode3` is 1, plane p's processed byte is `sr_val[p]` repeated eight times, and the effective mask is the rotated CPU byte ANDed with `bit_mask`.
- R7: When `mode2` and `mode3` are both 1, the block behaves exactly as in mode 3.
- R8: With both chain flags low, `plane_en` equals `map_mask` for a valid write.
- R9: With `chain4` high, `plane_en` is the one-hot bit selected by `addr_lo` (value n enables plane n), ANDed with `map_mask`. This holds whatever `chain2` is.
- R10: With `chain2` high and `chain4` low, `addr_lo[0]=0` enables planes 0 and 2, and `addr_lo[0]=1` enables planes 1 and 3. Both cases are ANDed with `map_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A CPU write is presented this cycle |
| cpu_data | input | 8 | CPU write byte |
| addr_lo | input | 2 | Low two bits of the CPU address |
| chain4 | input | 1 | Chain-4 write addressing |
| chain2 | input | 1 | Odd/even write addressing |
| map_mask | input | 4 | Per-plane write permission |
| mode2 | input | 1 | Write mode 2 select |
| mode3 | input | 1 | Write mode 3 select (wins over mode2) |
| rot_cnt | input | 3 | Right-rotate amount |
| sr_en | input | 4 | Per-plane set/reset enable |
| sr_val | input | 4 | Per-plane set/reset bit |
| bit_mask | input | 8 | 1 = processed data, 0 = latch |
| latch | input | 32 | Display latch, byte p for plane p |
| wr_data | output | 32 | Write word, byte p for plane p |
| plane_en | output | 4 | Registered plane write enables |
| wr_out_valid | output | 1 | Registered copy of wr_valid |

## Verification
The bench builds the block with its default byte width of 8, so the rotator has eight positions and the word holds four bytes. At this size every rotate count can be crossed with all four combinations of the mode flags and with several data, set/reset and mask patterns. The bench also runs every combination of chain flags, address bits and map mask, and checks the plane enable for each one.

// File: rtl/vga_plane_writer.sv
module vga_plane_writer #(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  input  logic [BYTE_W-1:0]     cpu_data,
  input  logic [1:0]            addr_lo,
  input  logic                  chain4,
  input  logic                  chain2,
  input  logic [3:0]            map_mask,
  input  logic                  mode2,
  input  logic                  mode3,
  input  logic [$clog2(BYTE_W)-1:0] rot_cnt,
  input  logic [3:0]            sr_en,
  input  logic [3:0]            sr_val,
  input  logic [BYTE_W-1:0]     bit_mask,
  input  logic [4*BYTE_W-1:0]   latch,
  output logic [4*BYTE_W-1:0]   wr_data,
  output logic [3:0]            plane_en,
  output logic                  wr_out_valid
);
  localparam int WORD_W = 4 * BYTE_W;

  logic [2*BYTE_W-1:0] rot_wide;
  logic [BYTE_W-1:0]   rot_byte;
  logic [BYTE_W-1:0]   eff_mask;
  logic [WORD_W-1:0]   nxt_data;
  logic [3:0]          chain_sel;
  logic [3:0]          nxt_en;

  assign rot_wide = {cpu_data, cpu_data} >> rot_cnt;
  assign rot_byte = rot_wide[BYTE_W-1:0];
  assign eff_mask = mode3 ? (rot_byte & bit_mask) : bit_mask;

  for (genvar p = 0; p < 4; p++) begin : g_plane
    logic [BYTE_W-1:0] fill;
    assign fill = mode3     ? {BYTE_W{sr_val[p]}}   :
                  mode2     ? {BYTE_W{cpu_data[p]}} :
                  sr_en[p]  ? {BYTE_W{sr_val[p]}}   : rot_byte;
    assign nxt_data[p*BYTE_W +: BYTE_W] =
      (fill & eff_mask) | (latch[p*BYTE_W +: BYTE_W] & ~eff_mask);
  end

  assign chain_sel = chain4 ? (4'b0001 << addr_lo) :
                     chain2 ? (addr_lo[0] ? 4'b1010 : 4'b0101) : 4'b1111;
  assign nxt_en = wr_valid ? (chain_sel & map_mask) : 4'b0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_data      <= '0;
      plane_en     <= '0;
      wr_out_valid <= 1'b0;
    end else begin
      wr_data      <= nxt_data;
      plane_en     <= nxt_en;
      wr_out_valid <= wr_valid;
    end
  end

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> (plane_en == 4'b0000 && !wr_out_valid));

  assert_mask_zero_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_mask == '0) |=> (wr_data == $past(latch)));

  assert_within_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> ((plane_en & ~$past(map_mask)) == 4'b0000));

  assert_chain4_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && chain4) |=> $onehot0(plane_en));

  assert_chain2_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && chain2 && !chain4) |=> ($countones(plane_en) <= 2));
endmodule

// File: tb/tb_vga_plane_writer.sv
module tb_vga_plane_writer;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, wr_valid = 0, chain4 = 0, chain2 = 0, mode2 = 0, mode3 = 0;
  logic [7:0] cpu_data = 0, bit_mask = 0;
  logic [1:0] addr_lo = 0;
  logic [3:0] map_mask = 0, sr_en = 0, sr_val = 0;
  logic [2:0] rot_cnt = 0;
  logic [31:0] latch = 0, wr_data;
  logic [3:0] plane_en;
  logic wr_out_valid;
  int errors = 0, checks = 0;
  logic done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vga_plane_writer dut (.clk, .rst_n, .wr_valid, .cpu_data, .addr_lo, .chain4, .chain2,
    .map_mask, .mode2, .mode3, .rot_cnt, .sr_en, .sr_val, .bit_mask, .latch,
    .wr_data, .plane_en, .wr_out_valid);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] model_word(logic [7:0] d, logic [2:0] r, logic m2, logic m3,
      logic [3:0] se, logic [3:0] sv, logic [7:0] bm, logic [31:0] lt);
    logic [7:0] rd, msk, src;
    logic [31:0] w;
    for (int i = 0; i < 8; i++) rd[i] = d[(i + r) % 8];
    msk = m3 ? (rd & bm) : bm;
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 8; i++) begin
        if (m3) src[i] = sv[p];
        else if (m2) src[i] = d[p];
        else if (se[p]) src[i] = sv[p];
        else src[i] = rd[i];
        w[8*p+i] = msk[i] ? src[i] : lt[8*p+i];
      end
    end
    return w;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] dats [4] = '{8'h00, 8'hA5, 8'h81, 8'h3C};
    logic [7:0] msks [3] = '{8'hFF, 8'h00, 8'h5A};
    logic [3:0] ses  [4] = '{4'h0, 4'hF, 4'h9, 4'h6};
    logic [3:0] svs  [4] = '{4'h0, 4'hF, 4'hC, 4'h5};
    latch = 32'hDEADBEEF;
    repeat (3) @(negedge clk);
    check("R1 reset data", wr_data, 0);
    check("R1 reset en", {28'd0, plane_en}, 0);
    check("R1 reset valid", {31'd0, wr_out_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    map_mask = 4'hF; wr_valid = 0;
    @(negedge clk);
    check("R1 idle en", {28'd0, plane_en}, 0);
    check("R1 idle valid", {31'd0, wr_out_valid}, 0);

    wr_valid = 1;
    for (int m = 0; m < 4; m++)
      for (int r = 0; r < 8; r++)
        for (int di = 0; di < 4; di++)
          for (int si = 0; si < 4; si++)
            for (int mi = 0; mi < 3; mi++) begin
              string tag;
              mode2 = m[0]; mode3 = m[1]; rot_cnt = 3'(r);
              cpu_data = dats[di]; sr_en = ses[si]; sr_val = svs[si ^ 1];
              bit_mask = msks[mi];
              latch = 32'hDEADBEEF ^ {4{dats[di] + 8'(r)}};
              if (m == 3) tag = "R7 mode3 priority";
              else if (m == 2) tag = "R6 mode3";
              else if (m == 1) tag = "R5 mode2";
              else if (msks[mi] != 8'hFF) tag = "R4 latch merge";
              else if (ses[si] != 0) tag = "R3 set/reset";
              else tag = "R2 rotate";
              @(negedge clk);
              check(tag, wr_data, model_word(cpu_data, rot_cnt, mode2, mode3,
                                             sr_en, sr_val, bit_mask, latch));
              check("R1 valid", {31'd0, wr_out_valid}, 1);
            end

    for (int c = 0; c < 4; c++)
      for (int a = 0; a < 4; a++)
        for (int mm = 0; mm < 16; mm++) begin
          logic [3:0] sel;
          string tag;
          chain4 = c[1]; chain2 = c[0]; addr_lo = 2'(a); map_mask = 4'(mm);
          if (c[1]) begin sel = 4'b0; sel[a] = 1'b1; tag = "R9 chain4"; end
          else if (c[0]) begin sel = a[0] ? 4'b1010 : 4'b0101; tag = "R10 chain2"; end
          else begin sel = 4'hF; tag = "R8 map mask"; end
          @(negedge clk);
          check(tag, {28'd0, plane_en}, {28'd0, sel & 4'(mm)});
        end

    wr_valid = 0;
    @(negedge clk);
    check("R1 idle after writes", {28'd0, plane_en}, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule